// File: doc/BRIEF.md
# Management-Port PHY Register Emulator

This block stands in for an Ethernet PHY that sits behind a host-side management command register. Software sees four host registers: a management control register, a 32-bit command register, a write-data register and a read-data register. Writing the command register with its initiate bit set starts one register transaction to a PHY address and register number. A write copies the write-data register into the PHY register file. A read places the PHY register value into the read-data register.

The emulated PHY answers at one configurable address. A read to any other address returns all ones, and a write to any other address is dropped. Most PHY registers are plain storage with fixed reset values. The status, link-partner ability and diagnostic registers are not stored. They are computed on every read from a link input and from the advertisement register. Every write to the PHY clears the self-clearing reset and restart-negotiation bits of the control register. No serial management timing is modelled: a transaction finishes one clock after the command is written.

Top module: `mgmt_phy_emu`

## Requirements
- R1: After reset the host control, write-data and read-data registers read 0. PHY registers 0, 2, 3 and 4 read 0x3100, 0x0300, 0xE400 and 0x01E1. Every other stored PHY register reads 0.
- R2: The command word holds the PHY address in bits 28:24, the register number in bits 20:16, the opcode in bits 15:14 and the initiate flag in bit 11. Opcode 1 with initiate writes the write-data value into the register. Opcode 2 with initiate loads the read-data register on the clock after the command write, and not on the command write itself. A command with bit 11 clear does nothing.
- R3: A command with initiate set and opcode 0 or 3 touches neither the register file nor the read-data register. It raises `cmd_bad` for exactly one cycle, two clocks after the command write.
- R4: A read to a PHY address other than `PHY_ADDR` (default 7) returns 0xFFFF. A write to such an address leaves every register unchanged.
- R5: Reading back the command register returns the last value written, with bit 7 always set.
- R6: PHY register 1 reads 0x782E when `link_up` is 1 (bits 14, 13, 12, 11, 5, 3, 2 and 1 set) and 0 when `link_up` is 0.
- R7: PHY register 5 reads 0x4000 OR (register 4 AND 0x01E0) OR 0x0001.
- R8: PHY register 18 reads 0 when the link is down. When the link is up, bit 10 equals register 4 bit 7 OR bit 8, bit 11 equals register 4 bit 8 OR bit 6, and all other bits are 0.
- R9: PHY register 17 always reads 0x8000, including after a write to it.
- R10: After any write to the PHY, bits 15 and 9 of register 0 are 0. For example, writing 0xFFFF to register 0 reads back as 0x7DFF.
- R11: The control register keeps only bits 6:0. Bit 6 is the enable and bits 5:0 are the clock divisor. `div_warn` is 1 exactly when the enable is set and the divisor is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link flag used by the computed registers |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Host register select for writes: 0 control, 1 command, 2 write data, 3 read data (writes to 3 are ignored) |
| wr_data | input | 32 | Host write value |
| rd_sel | input | 2 | Host register select for reads, same encoding as `wr_sel` |
| rd_data | output | 32 | Value of the selected host register |
| cmd_bad | output | 1 | One-cycle pulse for an initiated command with an invalid opcode |
| div_warn | output | 1 | Enable set while the divisor is zero |

## Verification
The bench checks the read-data register in the cycle right after the command write, where it must still hold its old value. A design that updated it on the command edge would show the new value one cycle too early. Writes to register 17 and writes to a foreign PHY address are each followed by reads through the normal command path. A design that stored register 17, or that ignored the address match, would return the written data instead of 0x8000 or the original contents. The bench walks the advertisement register through single-bit patterns and checks registers 5 and 18, which catches swapped or missing bits in the computed logic. Invalid opcodes are checked for the exact pulse timing and for leaving the read data untouched. Writing 0xFFFF to register 0 shows whether the two self-clearing bits are dropped.

// File: rtl/mphy_pkg.sv
package mphy_pkg;
  localparam int HOST_W   = 32;
  localparam int DW       = 16;
  localparam int FLD_AW   = 5;
  localparam int PHY_LSB  = 24;
  localparam int REG_LSB  = 16;
  localparam int OP_LSB   = 14;
  localparam int INIT_BIT = 11;
  localparam int RDY_BIT  = 7;
  localparam int CTRL_W   = 7;
  localparam int EN_BIT   = 6;
  localparam int DIV_W    = 6;

  localparam logic [FLD_AW-1:0] IDX_STAT = 5'd1;
  localparam logic [FLD_AW-1:0] IDX_ADV  = 5'd4;
  localparam logic [FLD_AW-1:0] IDX_LPA  = 5'd5;
  localparam logic [FLD_AW-1:0] IDX_SPEC = 5'd17;
  localparam logic [FLD_AW-1:0] IDX_DIAG = 5'd18;

  localparam logic [DW-1:0] STAT_UP   = 16'h782E;
  localparam logic [DW-1:0] LPA_BASE  = 16'h4001;
  localparam logic [DW-1:0] LPA_MASK  = 16'h01E0;
  localparam logic [DW-1:0] SPEC_VAL  = 16'h8000;
  localparam logic [DW-1:0] CLR_MASK  = 16'h8200;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CMD   = 2'd1,
    SEL_WDATA = 2'd2,
    SEL_RDATA = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2,
    OP_RSV  = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    logic              do_wr;
    logic              do_rd;
    logic              bad;
    logic              hit;
    logic [FLD_AW-1:0] reg_a;
  } cmd_act_t;

  function automatic logic [DW-1:0] reset_value(int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/mphy_rst_sync.sv
module mphy_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mphy_cmd_decode.sv
module mphy_cmd_decode
  import mphy_pkg::*;
#(
  parameter int PHY_ADDR = 7
) (
  input  logic [HOST_W-1:0] cmd_word,
  input  logic              go,
  output cmd_act_t          act
);
  localparam logic [FLD_AW-1:0] MY_ADDR = FLD_AW'(PHY_ADDR);

  logic [FLD_AW-1:0] phy_f;
  mgmt_op_e          op_f;

  always_comb begin
    phy_f     = cmd_word[PHY_LSB +: FLD_AW];
    op_f      = mgmt_op_e'(cmd_word[OP_LSB +: 2]);
    act.reg_a = cmd_word[REG_LSB +: FLD_AW];
    act.hit   = (phy_f == MY_ADDR);
    act.do_wr = go && (op_f == OP_WR) && act.hit;
    act.do_rd = go && (op_f == OP_RD);
    act.bad   = go && (op_f != OP_WR) && (op_f != OP_RD);
  end
endmodule

// File: rtl/mphy_regfile.sv
module mphy_regfile
  import mphy_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] adv
);
  logic [DW-1:0] mem_q [NREG];
  logic [DW-1:0] mem_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      mem_d[i] = mem_q[i];
      if (waddr == AW'(i)) mem_d[i] = wdata;
    end
    // entry 0 loses its self-clearing bits on any write
    mem_d[0] = mem_d[0] & ~CLR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= reset_value(i);
    end else if (we) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rdata = mem_q[raddr];
  assign adv   = mem_q[IDX_ADV];
endmodule

// File: rtl/mphy_view.sv
module mphy_view
  import mphy_pkg::*;
(
  input  logic [FLD_AW-1:0] reg_a,
  input  logic [DW-1:0]     stored,
  input  logic [DW-1:0]     adv,
  input  logic              link,
  output logic [DW-1:0]     value
);
  logic spd100, fdx;

  always_comb begin
    spd100 = adv[7] | adv[8];
    fdx    = adv[8] | adv[6];
    case (reg_a)
      IDX_STAT: value = link ? STAT_UP : '0;
      IDX_LPA:  value = LPA_BASE | (adv & LPA_MASK);
      IDX_SPEC: value = SPEC_VAL;
      IDX_DIAG: value = link ? DW'({fdx, spd100} << 10) : '0;
      default:  value = stored;
    endcase
  end
endmodule

// File: rtl/mgmt_phy_emu.sv
module mgmt_phy_emu
  import mphy_pkg::*;
#(
  parameter int PHY_ADDR = 7,
  parameter int NREG     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        cmd_bad,
  output logic        div_warn
);
  localparam int AW = $clog2(NREG);

  logic srst_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [HOST_W-1:0] cmd_q, cmd_d;
  logic [DW-1:0]     wdata_q, wdata_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  logic              go_q, go_d, bad_q;
  logic              ctrl_en, cmd_en, wdata_en, rdata_en;
  cmd_act_t          act;
  logic [DW-1:0]     stored_val, adv_val, view_val;

  mphy_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  mphy_cmd_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
    .cmd_word(cmd_q), .go(go_q), .act(act)
  );

  mphy_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(srst_n), .we(act.do_wr), .waddr(AW'(act.reg_a)),
    .wdata(wdata_q), .raddr(AW'(act.reg_a)), .rdata(stored_val), .adv(adv_val)
  );

  mphy_view u_view (
    .reg_a(act.reg_a), .stored(stored_val), .adv(adv_val),
    .link(link_up), .value(view_val)
  );

  // next-state logic
  always_comb begin
    ctrl_en  = wr_en && (wr_sel == SEL_CTRL);
    cmd_en   = wr_en && (wr_sel == SEL_CMD);
    wdata_en = wr_en && (wr_sel == SEL_WDATA);
    rdata_en = act.do_rd;
    ctrl_d   = wr_data[CTRL_W-1:0];
    cmd_d    = wr_data;
    wdata_d  = wr_data[DW-1:0];
    rdata_d  = act.hit ? view_val : '1;
    go_d     = cmd_en && wr_data[INIT_BIT];
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      go_q    <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (cmd_en)   cmd_q   <= cmd_d;
      if (wdata_en) wdata_q <= wdata_d;
      if (rdata_en) rdata_q <= rdata_d;
      go_q  <= go_d;
      bad_q <= act.bad;
    end
  end

  always_comb begin
    case (host_sel_e'(rd_sel))
      SEL_CTRL:  rd_data = HOST_W'(ctrl_q);
      SEL_CMD:   rd_data = cmd_q | (HOST_W'(1) << RDY_BIT);
      SEL_WDATA: rd_data = HOST_W'(wdata_q);
      default:   rd_data = HOST_W'(rdata_q);
    endcase
  end

  assign cmd_bad  = bad_q;
  assign div_warn = ctrl_q[EN_BIT] && (ctrl_q[DIV_W-1:0] == '0);
endmodule

// File: rtl/mphy_checker.sv
module mphy_checker #(
  parameter int PHY_ADDR = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [1:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        cmd_bad,
  input logic        div_warn,
  input logic [15:0] rdata_q
);
  logic cmd_go, bad_go, rd_go, rd_foreign, rd_spec;

  always_comb begin
    cmd_go     = wr_en && (wr_sel == 2'd1) && wr_data[11];
    bad_go     = cmd_go && ((wr_data[15:14] == 2'd0) || (wr_data[15:14] == 2'd3));
    rd_go      = cmd_go && (wr_data[15:14] == 2'd2);
    rd_foreign = rd_go && (wr_data[28:24] != 5'(PHY_ADDR));
    rd_spec    = rd_go && (wr_data[28:24] == 5'(PHY_ADDR)) && (wr_data[20:16] == 5'd17);
  end

  assert_bad_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad == $past(bad_go, 2));

  assert_foreign_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_foreign, 2) |-> (rdata_q == 16'hFFFF));

  assert_cmd_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd1) |-> rd_data[7]);

  assert_fixed_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_spec, 2) |-> (rdata_q == 16'h8000));

  assert_ctrl_warn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> ((rd_data[31:7] == '0) &&
                          (div_warn == (rd_data[6] && (rd_data[5:0] == 6'd0)))));
endmodule

bind mgmt_phy_emu mphy_checker #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .cmd_bad(cmd_bad), .div_warn(div_warn),
  .rdata_q(rdata_q)
);

// File: tb/mgmt_phy_emu_test.sv
module mgmt_phy_emu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_up;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        cmd_bad;
  logic        div_warn;

  int total = 0;
  int bad = 0;

  mgmt_phy_emu uut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cmd_bad(cmd_bad),
    .div_warn(div_warn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  task automatic phy_cmd(input logic [4:0] phy, input logic [4:0] ra,
                         input logic [1:0] op, input logic init);
    host_write(2'd1, {3'b0, phy, 3'b0, ra, op, 2'b0, init, 11'b0});
  endtask

  task automatic phy_read(input logic [4:0] phy, input logic [4:0] ra, output logic [15:0] v);
    logic [31:0] t;
    phy_cmd(phy, ra, 2'd2, 1'b1);
    @(negedge clk);
    host_read(2'd3, t);
    v = t[15:0];
  endtask

  task automatic phy_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    host_write(2'd2, {16'h0, d});
    phy_cmd(phy, ra, 2'd1, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v; logic [15:0] p;
    host_read(2'd0, v); check("R1 ctrl", v, 32'h0);
    host_read(2'd2, v); check("R1 wdata", v, 32'h0);
    host_read(2'd3, v); check("R1 rdata", v, 32'h0);
    check("R3 idle cmd_bad", {31'b0, cmd_bad}, 32'h0);
    phy_read(5'd7, 5'd0, p);  check("R1 reg0", {16'h0, p}, 32'h3100);
    phy_read(5'd7, 5'd2, p);  check("R1 reg2", {16'h0, p}, 32'h0300);
    phy_read(5'd7, 5'd3, p);  check("R1 reg3", {16'h0, p}, 32'hE400);
    phy_read(5'd7, 5'd4, p);  check("R1 reg4", {16'h0, p}, 32'h01E1);
    phy_read(5'd7, 5'd10, p); check("R1 reg10", {16'h0, p}, 32'h0);
  endtask

  task automatic t_status();
    logic [15:0] p;
    link_up = 1'b1;
    phy_read(5'd7, 5'd1, p);  check("R6 link up", {16'h0, p}, 32'h782E);
    phy_read(5'd7, 5'd18, p); check("R8 reset adv", {16'h0, p}, 32'h0C00);
    link_up = 1'b0;
    phy_read(5'd7, 5'd1, p);  check("R6 link down", {16'h0, p}, 32'h0);
    phy_read(5'd7, 5'd18, p); check("R8 link down", {16'h0, p}, 32'h0);
    link_up = 1'b1;
  endtask

  task automatic t_adv();
    logic [15:0] p;
    phy_read(5'd7, 5'd5, p);  check("R7 reset", {16'h0, p}, 32'h41E1);
    phy_write(5'd7, 5'd4, 16'h0040);
    phy_read(5'd7, 5'd5, p);  check("R7 10full", {16'h0, p}, 32'h4041);
    phy_read(5'd7, 5'd18, p); check("R8 10full", {16'h0, p}, 32'h0800);
    phy_write(5'd7, 5'd4, 16'h0080);
    phy_read(5'd7, 5'd18, p); check("R8 100half", {16'h0, p}, 32'h0400);
    phy_write(5'd7, 5'd4, 16'hFE1F);
    phy_read(5'd7, 5'd5, p);  check("R7 masked", {16'h0, p}, 32'h4001);
    phy_read(5'd7, 5'd18, p); check("R8 none", {16'h0, p}, 32'h0);
    phy_write(5'd7, 5'd4, 16'h0100);
    phy_read(5'd7, 5'd18, p); check("R8 100full", {16'h0, p}, 32'h0C00);
  endtask

  task automatic t_access();
    logic [15:0] p; logic [31:0] v;
    phy_write(5'd7, 5'd10, 16'h5A5A);
    phy_read(5'd7, 5'd2, p); check("R2 prior read", {16'h0, p}, 32'h0300);
    phy_cmd(5'd7, 5'd10, 2'd2, 1'b1);
    host_read(2'd3, v); check("R2 not yet", v, 32'h0300);
    @(negedge clk);
    host_read(2'd3, v); check("R2 read next cycle", v, 32'h5A5A);
    host_write(2'd2, 32'h0000_1111);
    phy_cmd(5'd7, 5'd10, 2'd1, 1'b0);
    @(negedge clk);
    phy_read(5'd7, 5'd10, p); check("R2 no initiate", {16'h0, p}, 32'h5A5A);
    phy_write(5'd7, 5'd17, 16'h1234);
    phy_read(5'd7, 5'd17, p); check("R9 fixed", {16'h0, p}, 32'h8000);
    phy_write(5'd7, 5'd0, 16'hFFFF);
    phy_read(5'd7, 5'd0, p); check("R10 self clear", {16'h0, p}, 32'h7DFF);
  endtask

  task automatic t_foreign();
    logic [15:0] p;
    phy_read(5'd3, 5'd2, p); check("R4 foreign read", {16'h0, p}, 32'hFFFF);
    phy_write(5'd3, 5'd10, 16'hAAAA);
    phy_read(5'd7, 5'd10, p); check("R4 foreign write dropped", {16'h0, p}, 32'h5A5A);
  endtask

  task automatic t_badop();
    logic [15:0] p; logic [31:0] v;
    phy_read(5'd7, 5'd2, p);
    host_write(2'd2, 32'h0000_2222);
    phy_cmd(5'd7, 5'd10, 2'd3, 1'b1);
    check("R3 not on first cycle", {31'b0, cmd_bad}, 32'h0);
    @(negedge clk);
    check("R3 pulse", {31'b0, cmd_bad}, 32'h1);
    @(negedge clk);
    check("R3 pulse ends", {31'b0, cmd_bad}, 32'h0);
    host_read(2'd3, v); check("R3 rdata kept", v, 32'h0300);
    phy_cmd(5'd7, 5'd10, 2'd0, 1'b1);
    @(negedge clk);
    check("R3 op0 pulse", {31'b0, cmd_bad}, 32'h1);
    phy_read(5'd7, 5'd10, p); check("R3 reg untouched", {16'h0, p}, 32'h5A5A);
  endtask

  task automatic t_hostregs();
    logic [31:0] v;
    host_write(2'd1, 32'h1234_5600);
    host_read(2'd1, v); check("R5 ready bit", v, 32'h1234_5680);
    host_write(2'd1, 32'h0);
    host_read(2'd1, v); check("R5 ready zero", v, 32'h0000_0080);
    host_write(2'd0, 32'hFFFF_FF45);
    host_read(2'd0, v); check("R11 low bits", v, 32'h45);
    check("R11 no warn", {31'b0, div_warn}, 32'h0);
    host_write(2'd0, 32'h40);
    check("R11 warn", {31'b0, div_warn}, 32'h1);
    host_write(2'd0, 32'h0);
    check("R11 disabled", {31'b0, div_warn}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_up = 1'b1; wr_en = 1'b0; wr_sel = 2'd0;
    wr_data = '0; rd_sel = 2'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_adv();
    t_access();
    t_foreign();
    t_badop();
    t_hostregs();
    summary();
    $finish;
  end
endmodule